// File: doc/BRIEF.md
# Converter Output Latency Aligner

This block is the digital back end of a pipelined analog-to-digital converter. Each 10-bit word is taken on the falling edge of the conversion clock. It travels down a shift chain that advances on both clock edges, so every stage adds half a clock. A tap is chosen from the chain so that the word reaches the bus after 5.5 clocks in the normal setup. When the conversion-clock polarity bit is set, the delay is 6.0 clocks. Routing the input through the gain amplifier adds 2 clocks to either figure. Words are straight binary and pass through unchanged.

The bus can be timed by the conversion clock itself. It can also be retimed by a separate output clock, on the rising or the falling edge of that clock. Three sources can turn the bus drivers off: an output-disable bit, a low standby pin and a power-down bit. When the drivers are off, the data lines read zero and the valid flag is low. The chain keeps shifting during that time, so the word that appears when the drivers return already has the correct latency. No state machine is used: the only sequencing is the fill of the chain after reset.

Top module: `adc_latency_aligner`

## Requirements
- R1: During reset and after it, `dout` is 0 and `dout_valid` is 0 until the first word sampled after reset reaches the selected tap.
- R2: With `conv_inv`=0 and `path_pga`=0, a word sampled on a falling edge of `clk_conv` appears on `dout` at the rising edge 11 half-clocks (5.5 clocks) later.
- R3: With `conv_inv`=1 and `path_pga`=0, the word appears on the falling edge 12 half-clocks (6.0 clocks) after sampling.
- R4: With `path_pga`=1, the delay grows by 4 half-clocks (2 clocks) to 15 or 16 half-clocks.
- R5: With `oclk_sel`=1 and `oclk_fall`=0, `dout` and `dout_valid` hold the tap contents captured at the last rising edge of `clk_out`.
- R6: With `oclk_sel`=1 and `oclk_fall`=1, the capture happens on the falling edge of `clk_out` instead.
- R7: `dout_oe` is 0 exactly when `out_dis`=1, `standby_n`=0 or `pwr_dn`=1, and `dout` is 0 while `dout_oe` is 0.
- R8: `dout_valid` is 0 while `dout_oe` is 0. The chain keeps shifting, so the first words after the drivers return are the words sampled one full latency earlier.
- R9: Coding is straight binary: the input word 10'h000 appears as 10'h000, 10'h3FF as 10'h3FF, and every bit keeps its position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_conv | input | 1 | Conversion clock; input sampled on its falling edge |
| clk_out | input | 1 | Separate output clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| din | input | 10 | Converted word, straight binary |
| conv_inv | input | 1 | Conversion-clock polarity: 1 gives a 6.0-clock delay, with output on the falling edge |
| path_pga | input | 1 | Input routed through the gain amplifier: 2 extra clocks |
| oclk_sel | input | 1 | 0: bus timed by clk_conv, 1: bus timed by clk_out |
| oclk_fall | input | 1 | With oclk_sel=1, 0 selects the rising edge and 1 the falling edge of clk_out |
| out_dis | input | 1 | Output-disable bit |
| standby_n | input | 1 | Standby pin, active low |
| pwr_dn | input | 1 | Power-down bit |
| dout | output | 10 | Output word, zero while drivers are off |
| dout_oe | output | 1 | Tri-state enable for the bus drivers |
| dout_valid | output | 1 | Output word is a real sample and the drivers are on |

## Verification
A stage that samples on the wrong edge, or a wrong tap index, moves every word on `dout` by one or more half-clocks. The independent bench model catches this at the first output edge after the chain fills, which is at most 16 half-clocks after reset or after a mode change. A stage that does not shift during the drivers-off period shows up as a stale or repeated word in the first cycle after `dout_oe` returns. Wrong valid-fill bits show up as `dout_valid` rising one half-clock early or late after reset. An error in the output-clock edge choice swaps which half of `clk_out` the bus changes on, and the next sample after the change of edge exposes it.

// File: rtl/alat_pkg.sv
package alat_pkg;
    localparam int ALAT_W          = 10;
    localparam int ALAT_BASE_HALF  = 11;
    localparam int ALAT_INV_HALF   = 1;
    localparam int ALAT_PGA_HALF   = 4;
endpackage

// File: rtl/alat_chain.sv
module alat_chain #(
    parameter int W      = 10,
    parameter int STAGES = 17
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [W-1:0]              din,
    output logic [STAGES-1:0][W-1:0]  q,
    output logic [STAGES-1:0]         vld
);
    // Stage k adds k half-clocks; even stages use the falling edge.
    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        logic [W-1:0] r;
        logic         v;
        logic [W-1:0] nxt_d;
        logic         nxt_v;
        if (k == 0) begin : g_head
            assign nxt_d = din;
            assign nxt_v = 1'b1;
        end else begin : g_body
            assign nxt_d = q[k-1];
            assign nxt_v = vld[k-1];
        end
        if (k % 2 == 0) begin : g_neg
            always_ff @(negedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    r <= '0;
                    v <= 1'b0;
                end else begin
                    r <= nxt_d;
                    v <= nxt_v;
                end
            end
        end else begin : g_pos
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    r <= '0;
                    v <= 1'b0;
                end else begin
                    r <= nxt_d;
                    v <= nxt_v;
                end
            end
        end
        assign q[k]   = r;
        assign vld[k] = v;
    end

    // R2: a word moves two stages per full clock within each edge bank
    for (genvar k = 0; k + 2 < STAGES; k++) begin : g_chk
        if (k % 2 == 1) begin : g_chk_pos
            a_r2_shift_pos: assert property (@(posedge clk) disable iff (!rst_n)
                q[k+2] == $past(q[k]));
            a_r8_fill_sticky: assert property (@(posedge clk) disable iff (!rst_n)
                $past(vld[k]) |-> vld[k]);
        end else begin : g_chk_neg
            a_r2_shift_neg: assert property (@(negedge clk) disable iff (!rst_n)
                q[k+2] == $past(q[k]));
        end
    end
endmodule

// File: rtl/alat_tap_sel.sv
module alat_tap_sel #(
    parameter int W      = 10,
    parameter int STAGES = 17,
    parameter int BASE   = 11,
    parameter int INV_X  = 1,
    parameter int PGA_X  = 4,
    localparam int IW    = $clog2(STAGES)
) (
    input  logic [STAGES-1:0][W-1:0] q,
    input  logic [STAGES-1:0]        vld,
    input  logic                     conv_inv,
    input  logic                     path_pga,
    output logic [W-1:0]             tap_d,
    output logic                     tap_v
);
    logic [IW-1:0] idx;

    always_comb begin
        idx = IW'(BASE + (conv_inv ? INV_X : 0) + (path_pga ? PGA_X : 0));
    end

    always_comb begin
        tap_d = q[idx];
        tap_v = vld[idx];
    end

    // R4: the tap never runs off the end of the chain
    always_comb begin
        a_r4_tap_in_range: assert (32'(idx) < STAGES);
    end
endmodule

// File: rtl/alat_retime.sv
module alat_retime #(
    parameter int W = 10
) (
    input  logic         clk_out,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    input  logic         dv,
    input  logic         fall_sel,
    output logic [W-1:0] q,
    output logic         qv
);
    logic [W-1:0] rise_d, fall_d;
    logic         rise_v, fall_v;

    always_ff @(posedge clk_out or negedge rst_n) begin
        if (!rst_n) begin
            rise_d <= '0;
            rise_v <= 1'b0;
        end else begin
            rise_d <= d;
            rise_v <= dv;
        end
    end

    always_ff @(negedge clk_out or negedge rst_n) begin
        if (!rst_n) begin
            fall_d <= '0;
            fall_v <= 1'b0;
        end else begin
            fall_d <= d;
            fall_v <= dv;
        end
    end

    always_comb begin
        q  = fall_sel ? fall_d : rise_d;
        qv = fall_sel ? fall_v : rise_v;
    end
endmodule

// File: rtl/adc_latency_aligner.sv
module adc_latency_aligner
    import alat_pkg::*;
#(
    parameter int W      = ALAT_W,
    parameter int BASE   = ALAT_BASE_HALF,
    parameter int INV_X  = ALAT_INV_HALF,
    parameter int PGA_X  = ALAT_PGA_HALF,
    localparam int STAGES = BASE + INV_X + PGA_X + 1
) (
    input  logic         clk_conv,
    input  logic         clk_out,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    input  logic         conv_inv,
    input  logic         path_pga,
    input  logic         oclk_sel,
    input  logic         oclk_fall,
    input  logic         out_dis,
    input  logic         standby_n,
    input  logic         pwr_dn,
    output logic [W-1:0] dout,
    output logic         dout_oe,
    output logic         dout_valid
);
    logic [STAGES-1:0][W-1:0] chain_q;
    logic [STAGES-1:0]        chain_v;
    logic [W-1:0]             tap_d, rt_d;
    logic                     tap_v, rt_v;
    logic [W-1:0]             sel_d;
    logic                     sel_v;

    alat_chain #(.W(W), .STAGES(STAGES)) u_chain (
        .clk   (clk_conv),
        .rst_n (rst_n),
        .din   (din),
        .q     (chain_q),
        .vld   (chain_v)
    );

    alat_tap_sel #(.W(W), .STAGES(STAGES), .BASE(BASE), .INV_X(INV_X),
                   .PGA_X(PGA_X)) u_tap (
        .q        (chain_q),
        .vld      (chain_v),
        .conv_inv (conv_inv),
        .path_pga (path_pga),
        .tap_d    (tap_d),
        .tap_v    (tap_v)
    );

    alat_retime #(.W(W)) u_retime (
        .clk_out  (clk_out),
        .rst_n    (rst_n),
        .d        (tap_d),
        .dv       (tap_v),
        .fall_sel (oclk_fall),
        .q        (rt_d),
        .qv       (rt_v)
    );

    always_comb begin
        sel_d      = oclk_sel ? rt_d : tap_d;
        sel_v      = oclk_sel ? rt_v : tap_v;
        dout_oe    = !(out_dis || !standby_n || pwr_dn);
        dout       = dout_oe ? sel_d : '0;
        dout_valid = dout_oe && sel_v;
    end

    // R8: no valid word is reported while the drivers are off
    a_r8_hiz_quiet: assert property (@(posedge clk_conv) disable iff (!rst_n)
        !dout_oe |-> (!dout_valid && dout == '0));
endmodule

// File: tb/adc_latency_aligner_bench.sv
`timescale 1ns/1ps
module adc_latency_aligner_bench;
    logic       clk_conv = 1'b0, clk_out = 1'b0, rst_n = 1'b0;
    logic [9:0] din = '0;
    logic       conv_inv = 0, path_pga = 0, oclk_sel = 0, oclk_fall = 0;
    logic       out_dis = 0, standby_n = 1, pwr_dn = 0;
    logic [9:0] dout;
    logic       dout_oe, dout_valid;

    // pending values, applied 1 ns after each clock edge
    logic       p_rst_n = 0, p_inv = 0, p_pga = 0, p_osel = 0, p_ofall = 0;
    logic       p_dis = 0, p_stby_n = 1, p_pdn = 0;

    int         h = 0;
    int         h_rel = 1 << 30;
    int         since_oe = 0;
    int         checks = 0, errors = 0;
    bit         bin_seg = 0, done = 0;
    logic [9:0] samp [0:8191];
    logic [10:0] exp_rise = '0, exp_fall = '0;

    adc_latency_aligner u_adc_latency_aligner (
        .clk_conv(clk_conv), .clk_out(clk_out), .rst_n(rst_n), .din(din),
        .conv_inv(conv_inv), .path_pga(path_pga), .oclk_sel(oclk_sel),
        .oclk_fall(oclk_fall), .out_dis(out_dis), .standby_n(standby_n),
        .pwr_dn(pwr_dn), .dout(dout), .dout_oe(dout_oe), .dout_valid(dout_valid)
    );

    function automatic int lat_halves();
        return 11 + (conv_inv ? 1 : 0) + (path_pga ? 4 : 0);
    endfunction

    // contents {valid, data} of the tap that the current config selects
    function automatic logic [10:0] tap_model();
        int l   = lat_halves();
        int hu  = (((h - l) % 2) == 0) ? h : h - 1;
        int src = hu - l;
        if (src >= 0 && src >= h_rel) return {1'b1, samp[src]};
        return 11'd0;
    endfunction

    function automatic string req_tag(bit oe, bit v);
        if (!rst_n || (oe && !v)) return "R1";
        if (!oe) return "R7,R8";
        if (since_oe < 30) return "R8";
        if (bin_seg) return "R9";
        if (oclk_sel) return oclk_fall ? "R6" : "R5";
        if (path_pga) return "R4";
        return conv_inv ? "R3" : "R2";
    endfunction

    task automatic check_out();
        bit          oe = !(out_dis || !standby_n || pwr_dn);
        logic [10:0] base = oclk_sel ? (oclk_fall ? exp_fall : exp_rise) : tap_model();
        logic [9:0]  ed = oe ? base[9:0] : 10'd0;
        bit          ev = oe && base[10];
        string       t = req_tag(oe, ev);
        checks++;
        if (dout !== ed || dout_valid !== ev || dout_oe !== oe) begin
            errors++;
            $display("FAIL %s h=%0d: dout=%h valid=%b oe=%b expected dout=%h valid=%b oe=%b",
                     t, h, dout, dout_valid, dout_oe, ed, ev, oe);
        end
    endtask

    task automatic half(input logic [9:0] nd);
        if (clk_conv) begin
            samp[h+1] = din;
            if (rst_n && h_rel > h + 1) h_rel = h + 1;
        end
        clk_conv = ~clk_conv;
        h++;
        #1;
        din = nd; rst_n = p_rst_n; conv_inv = p_inv; path_pga = p_pga;
        oclk_sel = p_osel; oclk_fall = p_ofall; out_dis = p_dis;
        standby_n = p_stby_n; pwr_dn = p_pdn;
        if (out_dis || !standby_n || pwr_dn) since_oe = 0; else since_oe++;
        #1;
        clk_out = ~clk_out;
        if (!rst_n) begin
            exp_rise = '0; exp_fall = '0;
        end else if (clk_out) exp_rise = tap_model();
        else exp_fall = tap_model();
        #2;
        check_out();
        #1;
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) half(10'($urandom));
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2718));
        // R1: reset state, then fill
        run(6);
        p_rst_n = 1;
        run(30);
        // R9: extreme and single-bit codes
        bin_seg = 1;
        for (int i = 0; i < 40; i++) begin
            case (i % 4)
                0: half(10'h000);
                1: half(10'h3FF);
                2: half(10'(1 << (i % 10)));
                default: half(~10'(1 << (i % 10)));
            endcase
        end
        bin_seg = 0;
        // R2, R3, R4: latency modes
        for (int m = 0; m < 4; m++) begin
            p_inv = m[0]; p_pga = m[1];
            run(40);
        end
        p_inv = 0; p_pga = 0;
        // R5, R6: output clock edges
        p_osel = 1; p_ofall = 0; run(40);
        p_ofall = 1; run(40);
        p_osel = 0; p_ofall = 0; run(20);
        // R7, R8: each driver-off source, with resumption
        p_dis = 1; run(10); p_dis = 0; run(30);
        p_stby_n = 0; run(10); p_stby_n = 1; run(30);
        p_pdn = 1; run(10); p_pdn = 0; run(30);
        // mixed random configurations
        for (int s = 0; s < 60; s++) begin
            p_inv = 1'($urandom); p_pga = 1'($urandom);
            p_osel = 1'($urandom); p_ofall = 1'($urandom);
            p_dis = ($urandom % 8) == 0;
            p_stby_n = ($urandom % 8) != 0;
            p_pdn = ($urandom % 8) == 0;
            run(80);
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule